// File: doc/BRIEF.md
# Multi-Thread Timeslot Gate Sequencer

This block schedules egress gates for a small switch. A single shared table of timeslots is walked over and over by up to eight independent threads. Each thread has three settings: a start offset added to a common base time, an entry address into the table, and an end index. Once a thread has started, it holds each slot for that slot's own duration and then steps to the next index. After its end index it goes back to its entry address.

Every slot carries three fields: a destination-port bitmask, an enable bit, and a closed-gate mask with one bit per traffic class. The block merges the slots that the running threads currently point at into one closed-gate mask per port. When two threads claim the same port, the lower-numbered thread takes priority, and a collision flag is raised.

Time is an external free-running counter that counts in the same units as the slot durations. Configuration is written through two valid/ready ports, one for table slots and one for thread settings.
- A port accepts a beat when valid and ready are both high at a rising edge.
- Ready is high only while the clock-source select is zero, that is, while the block is disabled.
- While the block runs, the sender must hold valid until ready returns. A beat presented while ready is low is not taken.

Top module: `tas_gate_sequencer`

## Requirements
- R1: Each gate bit is 0 after reset. Each gate bit is also 0 from the first rising edge at which the 2-bit clock-source select reads 0. Select values 1, 2 and 3 all run the threads.
- R2: `slot_wr_ready` and `thr_wr_ready` are high exactly while the select is 0. A write offered while ready is low changes nothing: the slot contents shown at the gate outputs stay as before.
- R3: Thread t runs only when t <= `active_m1`. It starts at the first rising edge where `now_time` >= `base_time` + its start offset. From that edge it shows the slot at its entry address. Threads numbered above `active_m1` never drive a gate.
- R4: A running thread shows each slot for as many rising edges as the slot's duration (a duration of 0 acts as 1). It then moves to the next index. After showing its end index it returns to its entry address.
- R5: Bit `gate_closed[p*NUM_TC + c]` set means traffic class c of port p is closed. The bit comes from the mask of a running thread's current slot when that slot has port bit p set and its enable bit set. A port with no such slot has all its bits at 0.
- R6: When several running threads have enabled slots naming the same port, the lowest-numbered thread's mask is driven. `collision` is high for as long as that overlap lasts.
- R7: With a nonzero select and `base_time` equal to 0, `base_err` is high one edge later, no thread starts, and every gate bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| clk_src | input | 2 | 0 off, 1 free-running, 2 alternate sync, 3 precision time; nonzero runs |
| active_m1 | input | THR_W | number of running threads minus one |
| base_time | input | TIME_W | schedule base time, must be nonzero |
| now_time | input | TIME_W | free-running time counter |
| slot_wr_valid | input | 1 | slot write beat valid |
| slot_wr_ready | output | 1 | slot write accepted (block disabled) |
| slot_wr_addr | input | IDX_W | slot index |
| slot_wr_delta | input | DELTA_W | slot duration |
| slot_wr_ports | input | NUM_PORTS | destination-port bitmask |
| slot_wr_gate_en | input | 1 | slot drives gates when set |
| slot_wr_mask | input | NUM_TC | closed-class mask |
| thr_wr_valid | input | 1 | thread write beat valid |
| thr_wr_ready | output | 1 | thread write accepted (block disabled) |
| thr_wr_idx | input | THR_W | thread number |
| thr_wr_start | input | TIME_W | start offset from base time |
| thr_wr_addr | input | IDX_W | entry address |
| thr_wr_end | input | IDX_W | end index |
| gate_closed | output | NUM_PORTS*NUM_TC | closed-gate mask per port and class |
| collision | output | 1 | two running threads claim one port |
| base_err | output | 1 | enabled with a zero base time |

## Verification
A wrong slot pointer or countdown value inside a thread reaches `gate_closed` in the same cycle, because the ports are decoded straight from thread state. A bench that samples every cycle over a few full periods therefore sees a shifted slot boundary at once. A thread that starts one edge early or late shows up as a one-cycle skew at its first slot. A bad wrap from the end index appears at the first period boundary. Priority and collision faults only become visible when two threads overlap on one port, so that case is set up on purpose.

// File: rtl/tas_pkg.sv
package tas_pkg;
  // clock-source select encodings; any nonzero value lets threads run
  typedef enum logic [1:0] {
    CS_OFF      = 2'd0,
    CS_FREE     = 2'd1,
    CS_SYNC_ALT = 2'd2,
    CS_PRECISE  = 2'd3
  } clk_src_e;
endpackage

// File: rtl/tas_slot_table.sv
module tas_slot_table #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned NUM_TC    = 8,
  parameter int unsigned DELTA_W   = 19,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     wr_addr,
  input  logic [DELTA_W-1:0]   wr_delta,
  input  logic [NUM_PORTS-1:0] wr_ports,
  input  logic                 wr_en,
  input  logic [NUM_TC-1:0]    wr_mask,
  output logic [DELTA_W-1:0]   delta_tbl [NUM_SLOTS],
  output logic [NUM_PORTS-1:0] ports_tbl [NUM_SLOTS],
  output logic                 en_tbl    [NUM_SLOTS],
  output logic [NUM_TC-1:0]    mask_tbl  [NUM_SLOTS]
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        delta_tbl[s] <= '0;
        ports_tbl[s] <= '0;
        en_tbl[s]    <= 1'b0;
        mask_tbl[s]  <= '0;
      end else if (we && wr_addr == IDX_W'(s)) begin
        delta_tbl[s] <= wr_delta;
        ports_tbl[s] <= wr_ports;
        en_tbl[s]    <= wr_en;
        mask_tbl[s]  <= wr_mask;
      end
    end
  end
endmodule

// File: rtl/tas_thread.sv
module tas_thread #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned TIME_W    = 32,
  parameter int unsigned DELTA_W   = 19,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               allowed,
  input  logic [TIME_W-1:0]  now_time,
  input  logic [TIME_W-1:0]  base_time,
  input  logic               cfg_we,
  input  logic [TIME_W-1:0]  cfg_start,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [IDX_W-1:0]   cfg_end,
  input  logic [DELTA_W-1:0] delta_tbl [NUM_SLOTS],
  output logic               busy,
  output logic [IDX_W-1:0]   slot
);
  logic [TIME_W-1:0]  start_q;
  logic [IDX_W-1:0]   entry_q, end_q;
  logic [DELTA_W-1:0] cnt_q;
  logic [IDX_W-1:0]   nxt;
  logic               go;

  // widened sum so a late offset cannot wrap into an early start
  assign go  = {1'b0, now_time} >= ({1'b0, base_time} + {1'b0, start_q});
  assign nxt = (slot == end_q || slot == IDX_W'(NUM_SLOTS - 1)) ? entry_q : slot + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      entry_q <= '0;
      end_q   <= '0;
    end else if (cfg_we) begin
      start_q <= cfg_start;
      entry_q <= cfg_addr;
      end_q   <= cfg_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      slot  <= '0;
      cnt_q <= '0;
    end else if (!run || !allowed) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        busy  <= 1'b1;
        slot  <= entry_q;
        cnt_q <= delta_tbl[entry_q];
      end
    end else if (cnt_q <= DELTA_W'(1)) begin
      slot  <= nxt;
      cnt_q <= delta_tbl[nxt];
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tas_gate_merge.sv
module tas_gate_merge #(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned NUM_SLOTS   = 16,
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned NUM_TC      = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_THREADS-1:0]  busy,
  input  logic [IDX_W-1:0]        slot [NUM_THREADS],
  input  logic [NUM_PORTS-1:0]    ports_tbl [NUM_SLOTS],
  input  logic                    en_tbl    [NUM_SLOTS],
  input  logic [NUM_TC-1:0]       mask_tbl  [NUM_SLOTS],
  output logic [NUM_PORTS*NUM_TC-1:0] gate_closed,
  output logic                    collision
);
  always_comb begin
    gate_closed = '0;
    collision   = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic taken;
      taken = 1'b0;
      // ascending scan: the first claimant keeps the port
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (busy[t] && en_tbl[slot[t]] && ports_tbl[slot[t]][p]) begin
          if (taken) begin
            collision = 1'b1;
          end else begin
            gate_closed[p*NUM_TC +: NUM_TC] = mask_tbl[slot[t]];
            taken = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tas_gate_sequencer.sv
module tas_gate_sequencer #(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned NUM_SLOTS   = 16,
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned NUM_TC      = 8,
  parameter int unsigned TIME_W      = 32,
  parameter int unsigned DELTA_W     = 19,
  localparam int unsigned IDX_W      = $clog2(NUM_SLOTS),
  localparam int unsigned THR_W      = $clog2(NUM_THREADS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  clk_src,
  input  logic [THR_W-1:0]            active_m1,
  input  logic [TIME_W-1:0]           base_time,
  input  logic [TIME_W-1:0]           now_time,
  input  logic                        slot_wr_valid,
  output logic                        slot_wr_ready,
  input  logic [IDX_W-1:0]            slot_wr_addr,
  input  logic [DELTA_W-1:0]          slot_wr_delta,
  input  logic [NUM_PORTS-1:0]        slot_wr_ports,
  input  logic                        slot_wr_gate_en,
  input  logic [NUM_TC-1:0]           slot_wr_mask,
  input  logic                        thr_wr_valid,
  output logic                        thr_wr_ready,
  input  logic [THR_W-1:0]            thr_wr_idx,
  input  logic [TIME_W-1:0]           thr_wr_start,
  input  logic [IDX_W-1:0]            thr_wr_addr,
  input  logic [IDX_W-1:0]            thr_wr_end,
  output logic [NUM_PORTS*NUM_TC-1:0] gate_closed,
  output logic                        collision,
  output logic                        base_err
);
  import tas_pkg::*;

  logic                 enabled, run;
  logic [DELTA_W-1:0]   delta_tbl [NUM_SLOTS];
  logic [NUM_PORTS-1:0] ports_tbl [NUM_SLOTS];
  logic                 en_tbl    [NUM_SLOTS];
  logic [NUM_TC-1:0]    mask_tbl  [NUM_SLOTS];
  logic [NUM_THREADS-1:0] busy;
  logic [IDX_W-1:0]     slot [NUM_THREADS];

  assign enabled       = clk_src_e'(clk_src) != CS_OFF;
  assign run           = enabled && (base_time != '0);
  assign slot_wr_ready = !enabled;
  assign thr_wr_ready  = !enabled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_err <= 1'b0;
    else        base_err <= enabled && (base_time == '0);
  end

  tas_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC), .DELTA_W(DELTA_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(slot_wr_valid && slot_wr_ready),
    .wr_addr(slot_wr_addr), .wr_delta(slot_wr_delta), .wr_ports(slot_wr_ports),
    .wr_en(slot_wr_gate_en), .wr_mask(slot_wr_mask),
    .delta_tbl(delta_tbl), .ports_tbl(ports_tbl), .en_tbl(en_tbl), .mask_tbl(mask_tbl)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    tas_thread #(
      .NUM_SLOTS(NUM_SLOTS), .TIME_W(TIME_W), .DELTA_W(DELTA_W)
    ) u_thr (
      .clk(clk), .rst_n(rst_n),
      .run(run),
      .allowed(THR_W'(t) <= active_m1),
      .now_time(now_time), .base_time(base_time),
      .cfg_we(thr_wr_valid && thr_wr_ready && thr_wr_idx == THR_W'(t)),
      .cfg_start(thr_wr_start), .cfg_addr(thr_wr_addr), .cfg_end(thr_wr_end),
      .delta_tbl(delta_tbl),
      .busy(busy[t]), .slot(slot[t])
    );
  end

  tas_gate_merge #(
    .NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS), .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC)
  ) u_merge (
    .busy(busy), .slot(slot),
    .ports_tbl(ports_tbl), .en_tbl(en_tbl), .mask_tbl(mask_tbl),
    .gate_closed(gate_closed), .collision(collision)
  );
endmodule

// File: rtl/tas_gate_sequencer_chk.sv
module tas_gate_sequencer_chk #(
  parameter int unsigned GATE_W = 32,
  parameter int unsigned TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        clk_src,
  input logic [TIME_W-1:0] base_time,
  input logic              slot_wr_ready,
  input logic              thr_wr_ready,
  input logic [GATE_W-1:0] gate_closed,
  input logic              collision,
  input logic              base_err
);
  // R1
  gates_open_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src == 2'd0) |=> (gate_closed == '0));
  // R2
  cfg_blocked_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src != 2'd0) |-> (!slot_wr_ready && !thr_wr_ready));
  // R6
  no_overlap_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src == 2'd0) |=> !collision);
  // R7
  zero_base_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src != 2'd0 && base_time == '0) |=> base_err);
  // R7
  zero_base_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_time == '0) |=> (gate_closed == '0));
endmodule

bind tas_gate_sequencer tas_gate_sequencer_chk #(
  .GATE_W(NUM_PORTS*NUM_TC), .TIME_W(TIME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .base_time(base_time),
  .slot_wr_ready(slot_wr_ready), .thr_wr_ready(thr_wr_ready),
  .gate_closed(gate_closed), .collision(collision), .base_err(base_err)
);

// File: tb/test_tas_gate_sequencer.sv
module test_tas_gate_sequencer;
  localparam int NT = 8, NS = 16, NP = 4, TC = 8, TW = 32, DW = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] clk_src = '0;
  logic [2:0] active_m1 = '0;
  logic [TW-1:0] base_time = 32'd10, now_time = '0;
  logic slot_wr_valid = 1'b0, slot_wr_ready, slot_wr_gate_en = 1'b0;
  logic [3:0] slot_wr_addr = '0;
  logic [DW-1:0] slot_wr_delta = '0;
  logic [NP-1:0] slot_wr_ports = '0;
  logic [TC-1:0] slot_wr_mask = '0;
  logic thr_wr_valid = 1'b0, thr_wr_ready;
  logic [2:0] thr_wr_idx = '0;
  logic [TW-1:0] thr_wr_start = '0;
  logic [3:0] thr_wr_addr = '0, thr_wr_end = '0;
  logic [NP*TC-1:0] gate_closed;
  logic collision, base_err;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tas_gate_sequencer i_tas_gate_sequencer (.*);

  // {time, port0 mask, port1 mask, port2 mask} seen after the edge at that time
  localparam logic [31:0] VEC [17] = '{
    32'h0A_00_00_00, 32'h0B_00_00_00, 32'h0C_0F_00_00, 32'h0D_0F_00_00,
    32'h0E_0F_00_00, 32'h0F_F0_55_00, 32'h10_F0_55_00, 32'h11_0F_55_00,
    32'h12_0F_55_00, 32'h13_0F_AA_AA, 32'h14_F0_55_00, 32'h15_F0_55_00,
    32'h16_0F_55_00, 32'h17_0F_55_00, 32'h18_0F_AA_AA, 32'h19_F0_55_00,
    32'h1A_F0_55_00
  };

  function automatic logic [7:0] pm(input int p);
    return gate_closed[p*TC +: TC];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_slot(input int a, input int d, input logic [3:0] pts,
                         input logic en, input logic [7:0] m);
    slot_wr_valid = 1'b1; slot_wr_addr = 4'(a); slot_wr_delta = DW'(d);
    slot_wr_ports = pts; slot_wr_gate_en = en; slot_wr_mask = m;
    @(negedge clk);
    slot_wr_valid = 1'b0;
  endtask

  task automatic wr_thr(input int t, input int st, input int a, input int e);
    thr_wr_valid = 1'b1; thr_wr_idx = 3'(t); thr_wr_start = TW'(st);
    thr_wr_addr = 4'(a); thr_wr_end = 4'(e);
    @(negedge clk);
    thr_wr_valid = 1'b0;
  endtask

  // start at time 10, step one time unit per cycle up to 'last'
  task automatic run_to(input int last);
    clk_src = 2'd1;
    for (int t = 10; t <= last; t++) begin
      now_time = TW'(t);
      @(negedge clk);
    end
  endtask

  task automatic stop_run();
    clk_src = 2'd0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset gates", 32'(gate_closed), 32'h0);
    check("R2 reset ready", {30'd0, slot_wr_ready, thr_wr_ready}, 32'h3);
    rst_n = 1'b1;
    @(negedge clk);

    wr_slot(0, 3, 4'b0001, 1'b1, 8'h0F);
    wr_slot(1, 2, 4'b0001, 1'b1, 8'hF0);
    wr_slot(2, 4, 4'b0010, 1'b1, 8'h55);
    wr_slot(3, 1, 4'b0110, 1'b1, 8'hAA);
    wr_thr(0, 2, 0, 1);
    for (int t = 1; t < NT; t++) wr_thr(t, 5, 2, 3);

    // two threads, walked over several periods (R3 R4 R5)
    active_m1 = 3'd1;
    clk_src = 2'd1;
    for (int i = 0; i < 17; i++) begin
      now_time = TW'(VEC[i][31:24]);
      @(negedge clk);
      check("R3 R4 R5 port0", 32'(pm(0)), 32'(VEC[i][23:16]));
      check("R4 R5 port1",    32'(pm(1)), 32'(VEC[i][15:8]));
      check("R5 port2",       32'(pm(2)), 32'(VEC[i][7:0]));
      check("R5 port3",       32'(pm(3)), 32'h0);
      check("R6 no overlap",  32'(collision), 32'h0);
    end

    // write offered while running is refused
    check("R2 ready low", {30'd0, slot_wr_ready, thr_wr_ready}, 32'h0);
    slot_wr_valid = 1'b1; slot_wr_addr = 4'd0; slot_wr_mask = 8'hFF;
    slot_wr_delta = DW'(9); slot_wr_ports = 4'b0001; slot_wr_gate_en = 1'b1;
    now_time = 32'd27;
    @(negedge clk);
    slot_wr_valid = 1'b0;
    check("R2 ignored write", 32'(pm(0)), 32'h0F);

    stop_run();
    check("R1 disabled gates", 32'(gate_closed), 32'h0);
    check("R2 ready back", {30'd0, slot_wr_ready, thr_wr_ready}, 32'h3);

    // one thread only; select value 3 also runs
    active_m1 = 3'd0;
    clk_src = 2'd3;
    for (int t = 10; t <= 16; t++) begin now_time = TW'(t); @(negedge clk); end
    check("R3 thread0 runs", 32'(pm(0)), 32'hF0);
    check("R3 thread1 idle", 32'(pm(1)), 32'h0);
    stop_run();

    // zero base time
    base_time = '0;
    clk_src = 2'd1;
    now_time = 32'd50;
    @(negedge clk);
    check("R7 flag", 32'(base_err), 32'h1);
    repeat (3) @(negedge clk);
    check("R7 no start", 32'(gate_closed), 32'h0);
    base_time = 32'd10;
    stop_run();
    check("R7 flag clears", 32'(base_err), 32'h0);

    // overlap on port 0
    wr_slot(4, 5, 4'b0001, 1'b1, 8'h33);
    wr_thr(1, 5, 4, 4);
    active_m1 = 3'd1;
    run_to(14);
    check("R6 before overlap", 32'(collision), 32'h0);
    check("R6 port0 alone", 32'(pm(0)), 32'h0F);
    now_time = 32'd15; @(negedge clk);
    now_time = 32'd16; @(negedge clk);
    check("R6 overlap flag", 32'(collision), 32'h1);
    check("R6 lower wins", 32'(pm(0)), 32'hF0);
    stop_run();

    // slot with enable clear leaves its port open
    wr_slot(4, 5, 4'b1000, 1'b0, 8'hFF);
    run_to(16);
    check("R5 enable clear", 32'(pm(3)), 32'h0);
    check("R5 enable clear no overlap", 32'(collision), 32'h0);
    stop_run();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule